// File: doc/BRIEF.md
# Dual-FIFO SPI Data Buffer

This block holds the two data queues between a register bus and an SPI shift engine. The transmit queue is filled from the bus side and drained by the engine. The receive queue is filled by the engine and drained by the bus side. Each queue reports four status flags: empty, full, "one frame left" (the next read empties it) and "one slot left" (the next write fills it). Each queue has its own single-cycle clear command.

The bus-side write, the bus-side read and the engine-side transmit pop are valid/ready streams. A transfer happens on a clock edge where both valid and ready are high. The bus writer is held off by `bus_tx_ready` low while the transmit queue is full. The bus reader and the engine see `valid` low while their queue is empty.

The engine's receive push cannot be stalled, so it has no ready. A frame pushed while the receive queue is full is dropped, and a receive-overflow event is raised. When the engine asks for a transmit frame from an empty queue during an active transfer, a transmit-underrun event is raised. The block also gives a one-cycle pulse for every frame sent and every frame stored. Overflow and underrun each have a sticky flag.

Top module: `spi_dual_fifo`

## Requirements
- R1: After reset both queues are empty: empty=1, full=0, both early-warning flags 0, all event pulses and sticky flags 0, and `bus_tx_ready`=1.
- R2: Each queue holds DEPTH (default 32) frames and returns them in the order written. A write offered to a full transmit queue is not accepted and does not change its contents.
- R3: `*_full_next` is 1 exactly when the queue holds DEPTH-1 frames. `*_empty_next` is 1 exactly when it holds one frame.
- R4: `tx_flush` and `rx_flush` each empty their own queue at the next edge. They may be issued together. A clear takes priority over a push or pop in the same cycle, and it clears that queue's sticky flag.
- R5: An engine push while `rx_full`=1 drops the frame and leaves the stored frames unchanged. `rx_overflow` pulses for one cycle after that edge, and `rx_overflow_seen` is set and stays set until `rx_flush`.
- R6: An engine pop request (`eng_tx_ready`=1) while the transmit queue is empty and `eng_active`=1 pulses `tx_underrun` one cycle after that edge and sets `tx_underrun_seen`. The same request with `eng_active`=0 raises nothing.
- R7: `tx_sent` pulses in the cycle after each frame the engine takes. `rx_rcvd` pulses in the cycle after each frame stored in the receive queue, and not for a dropped frame.
- R8: A push and a pop in the same cycle are judged on the count before the edge. On a full queue only the pop happens (count DEPTH-1). On an empty queue only the push happens (count 1). Otherwise the count stays the same.
- R9: `bus_tx_ready` = not transmit full. `eng_tx_valid` = not transmit empty. `bus_rx_valid` = not receive empty. The presented data is the oldest stored frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_tx_valid | input | 1 | Bus offers a transmit frame |
| bus_tx_data | input | DATA_W | Transmit frame from bus |
| bus_tx_ready | output | 1 | Transmit queue can accept |
| bus_rx_valid | output | 1 | Received frame available to bus |
| bus_rx_data | output | DATA_W | Oldest received frame |
| bus_rx_ready | input | 1 | Bus takes the received frame |
| eng_tx_valid | output | 1 | Transmit frame available to engine |
| eng_tx_data | output | DATA_W | Oldest transmit frame |
| eng_tx_ready | input | 1 | Engine requests/takes a frame |
| eng_active | input | 1 | Engine is mid-transfer |
| eng_rx_valid | input | 1 | Engine pushes a received frame |
| eng_rx_data | input | DATA_W | Received frame from engine |
| tx_flush | input | 1 | Clear transmit queue |
| rx_flush | input | 1 | Clear receive queue |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| tx_empty_next | output | 1 | Transmit queue holds one frame |
| tx_full_next | output | 1 | Transmit queue holds DEPTH-1 frames |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_empty_next | output | 1 | Receive queue holds one frame |
| rx_full_next | output | 1 | Receive queue holds DEPTH-1 frames |
| tx_sent | output | 1 | Pulse: engine took a frame |
| rx_rcvd | output | 1 | Pulse: received frame stored |
| tx_underrun | output | 1 | Pulse: pop from empty during transfer |
| rx_overflow | output | 1 | Pulse: push into full receive queue |
| tx_underrun_seen | output | 1 | Sticky underrun flag |
| rx_overflow_seen | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its default values, DATA_W=8 and DEPTH=32. With these values both queues reach the full boundary after 32 pushes, which puts the early-warning flags, the blocked write, overflow, and a push and pop together on a full queue within a few dozen cycles. A scoreboard checks frame order through every fill and drain, and checks each event pulse in every cycle against the handshakes seen in the cycle before.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  parameter int unsigned DEF_DATA_W = 8;
  parameter int unsigned DEF_DEPTH  = 32;

  typedef struct packed {
    logic empty;
    logic full;
    logic empty_next;
    logic full_next;
  } fifo_flags_t;
endpackage

// File: rtl/spi_fifo_core.sv
module spi_fifo_core
  import spi_fifo_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output fifo_flags_t   flags,
  output logic          push_ok,
  output logic          pop_ok
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_LAST = CW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp, wp_nx, rp_nx;
  logic [CW-1:0] cnt;

  // Pointer wrap: free-running for power-of-two depths, compare otherwise.
  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wp_nx = wp + 1'b1;
      assign rp_nx = rp + 1'b1;
    end else begin : g_wrap
      assign wp_nx = (wp == PTR_LAST) ? '0 : wp + 1'b1;
      assign rp_nx = (rp == PTR_LAST) ? '0 : rp + 1'b1;
    end
  endgenerate

  // Acceptance judged on the count before the edge; a clear wins.
  assign push_ok = push & ~flush & (cnt != CNT_FULL);
  assign pop_ok  = pop  & ~flush & (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= wp_nx;
      if (pop_ok)  rp <= rp_nx;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
  end

  assign rdata            = mem[rp];
  assign flags.empty      = (cnt == '0);
  assign flags.full       = (cnt == CNT_FULL);
  assign flags.empty_next = (cnt == CNT_ONE);
  assign flags.full_next  = (cnt == CNT_LAST);

  p_flush_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (flags.empty && !flags.full));
  p_full_push_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.full && push && !pop && !flush) |=> flags.full);
  p_empty_pop_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.empty && pop && !push && !flush) |=> flags.empty);
  p_last_slot_fills_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.full_next && push && !pop && !flush) |=> flags.full);
  p_last_frame_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.empty_next && pop && !push && !flush) |=> flags.empty);
  p_count_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_FULL);
endmodule

// File: rtl/spi_fifo_events.sv
module spi_fifo_events (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_pop_req,
  input  logic tx_pop_ok,
  input  logic tx_is_empty,
  input  logic active,
  input  logic tx_clr,
  input  logic rx_push_req,
  input  logic rx_push_ok,
  input  logic rx_is_full,
  input  logic rx_clr,
  output logic sent,
  output logic rcvd,
  output logic udr,
  output logic ovf,
  output logic udr_seen,
  output logic ovf_seen
);
  logic udr_now, ovf_now;

  assign udr_now = tx_pop_req & tx_is_empty & active & ~tx_clr;
  assign ovf_now = rx_push_req & rx_is_full & ~rx_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent     <= 1'b0;
      rcvd     <= 1'b0;
      udr      <= 1'b0;
      ovf      <= 1'b0;
      udr_seen <= 1'b0;
      ovf_seen <= 1'b0;
    end else begin
      sent     <= tx_pop_ok;
      rcvd     <= rx_push_ok;
      udr      <= udr_now;
      ovf      <= ovf_now;
      udr_seen <= tx_clr ? 1'b0 : (udr_seen | udr_now);
      ovf_seen <= rx_clr ? 1'b0 : (ovf_seen | ovf_now);
    end
  end

  p_ovf_marks_seen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> ovf_seen);
  p_ovf_seen_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_seen && !rx_clr) |=> ovf_seen);
  p_udr_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !udr);
  p_udr_seen_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (udr_seen && !tx_clr) |=> udr_seen);
  p_drop_no_rcvd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> !rcvd);
endmodule

// File: rtl/spi_dual_fifo.sv
module spi_dual_fifo
  import spi_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned DEPTH  = DEF_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_tx_valid,
  input  logic [DATA_W-1:0] bus_tx_data,
  output logic              bus_tx_ready,
  output logic              bus_rx_valid,
  output logic [DATA_W-1:0] bus_rx_data,
  input  logic              bus_rx_ready,
  output logic              eng_tx_valid,
  output logic [DATA_W-1:0] eng_tx_data,
  input  logic              eng_tx_ready,
  input  logic              eng_active,
  input  logic              eng_rx_valid,
  input  logic [DATA_W-1:0] eng_rx_data,
  input  logic              tx_flush,
  input  logic              rx_flush,
  output logic              tx_empty,
  output logic              tx_full,
  output logic              tx_empty_next,
  output logic              tx_full_next,
  output logic              rx_empty,
  output logic              rx_full,
  output logic              rx_empty_next,
  output logic              rx_full_next,
  output logic              tx_sent,
  output logic              rx_rcvd,
  output logic              tx_underrun,
  output logic              rx_overflow,
  output logic              tx_underrun_seen,
  output logic              rx_overflow_seen
);
  fifo_flags_t tx_fl, rx_fl;
  logic tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;

  spi_fifo_core #(.DW(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(bus_tx_valid), .wdata(bus_tx_data),
    .pop(eng_tx_ready), .rdata(eng_tx_data),
    .flags(tx_fl), .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  spi_fifo_core #(.DW(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(eng_rx_valid), .wdata(eng_rx_data),
    .pop(bus_rx_ready), .rdata(bus_rx_data),
    .flags(rx_fl), .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  spi_fifo_events u_evt (
    .clk(clk), .rst_n(rst_n),
    .tx_pop_req(eng_tx_ready), .tx_pop_ok(tx_pop_ok), .tx_is_empty(tx_fl.empty),
    .active(eng_active), .tx_clr(tx_flush),
    .rx_push_req(eng_rx_valid), .rx_push_ok(rx_push_ok), .rx_is_full(rx_fl.full),
    .rx_clr(rx_flush),
    .sent(tx_sent), .rcvd(rx_rcvd), .udr(tx_underrun), .ovf(rx_overflow),
    .udr_seen(tx_underrun_seen), .ovf_seen(rx_overflow_seen)
  );

  assign bus_tx_ready  = ~tx_fl.full;
  assign eng_tx_valid  = ~tx_fl.empty;
  assign bus_rx_valid  = ~rx_fl.empty;
  assign tx_empty      = tx_fl.empty;
  assign tx_full       = tx_fl.full;
  assign tx_empty_next = tx_fl.empty_next;
  assign tx_full_next  = tx_fl.full_next;
  assign rx_empty      = rx_fl.empty;
  assign rx_full       = rx_fl.full;
  assign rx_empty_next = rx_fl.empty_next;
  assign rx_full_next  = rx_fl.full_next;

  p_tx_handshake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_tx_valid && !bus_tx_ready && !eng_tx_ready && !tx_flush) |=> tx_full);
  p_rx_pop_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rx_ready && !bus_rx_valid && !eng_rx_valid && !rx_flush) |=> rx_empty);
  p_ignored_pop_unused_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_pop_ok |-> !(bus_rx_ready && bus_rx_valid && !rx_flush));
  p_push_used_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_tx_valid && bus_tx_ready && !tx_flush) |-> tx_push_ok);
endmodule

// File: tb/spi_dual_fifo_tb.sv
module spi_dual_fifo_tb;
  localparam int DW = 8;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_tx_valid = 0, bus_rx_ready = 0, eng_tx_ready = 0, eng_active = 0;
  logic eng_rx_valid = 0, tx_flush = 0, rx_flush = 0;
  logic [DW-1:0] bus_tx_data = '0, eng_rx_data = '0;
  logic bus_tx_ready, bus_rx_valid, eng_tx_valid;
  logic [DW-1:0] bus_rx_data, eng_tx_data;
  logic tx_empty, tx_full, tx_empty_next, tx_full_next;
  logic rx_empty, rx_full, rx_empty_next, rx_full_next;
  logic tx_sent, rx_rcvd, tx_underrun, rx_overflow, tx_underrun_seen, rx_overflow_seen;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [DW-1:0] tx_q[$];
  logic [DW-1:0] rx_q[$];

  always #10 clk = ~clk;

  spi_dual_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .bus_tx_valid(bus_tx_valid), .bus_tx_data(bus_tx_data), .bus_tx_ready(bus_tx_ready),
    .bus_rx_valid(bus_rx_valid), .bus_rx_data(bus_rx_data), .bus_rx_ready(bus_rx_ready),
    .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data), .eng_tx_ready(eng_tx_ready),
    .eng_active(eng_active), .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data),
    .tx_flush(tx_flush), .rx_flush(rx_flush),
    .tx_empty(tx_empty), .tx_full(tx_full), .tx_empty_next(tx_empty_next),
    .tx_full_next(tx_full_next), .rx_empty(rx_empty), .rx_full(rx_full),
    .rx_empty_next(rx_empty_next), .rx_full_next(rx_full_next),
    .tx_sent(tx_sent), .rx_rcvd(rx_rcvd), .tx_underrun(tx_underrun),
    .rx_overflow(rx_overflow), .tx_underrun_seen(tx_underrun_seen),
    .rx_overflow_seen(rx_overflow_seen)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic chk1(input logic act, input logic exp, input string what);
    chk(act === exp, what, int'(act), int'(exp));
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Monitor: scoreboard and per-cycle event checks, sampled mid-cycle.
  logic p_txf = 0, p_rxs = 0, p_udr = 0, p_ovf = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk1(tx_sent, p_txf, "R7 tx_sent pulse");
      chk1(rx_rcvd, p_rxs, "R7 rx_rcvd pulse");
      chk1(tx_underrun, p_udr, "R6 tx_underrun pulse");
      chk1(rx_overflow, p_ovf, "R5 rx_overflow pulse");
      p_txf = eng_tx_ready && eng_tx_valid && !tx_flush;
      p_rxs = eng_rx_valid && !rx_full && !rx_flush;
      p_udr = eng_tx_ready && !eng_tx_valid && eng_active && !tx_flush;
      p_ovf = eng_rx_valid && rx_full && !rx_flush;
      if (tx_flush) tx_q.delete();
      if (rx_flush) rx_q.delete();
      if (p_txf) begin
        if (tx_q.size() == 0) chk(0, "R2 tx pop with empty model", int'(eng_tx_data), 0);
        else begin
          logic [DW-1:0] e;
          e = tx_q.pop_front();
          chk(eng_tx_data === e, "R2 tx order", int'(eng_tx_data), int'(e));
        end
      end
      if (bus_tx_valid && bus_tx_ready && !tx_flush) tx_q.push_back(bus_tx_data);
      if (bus_rx_valid && bus_rx_ready && !rx_flush) begin
        if (rx_q.size() == 0) chk(0, "R5 rx read with empty model", int'(bus_rx_data), 0);
        else begin
          logic [DW-1:0] e;
          e = rx_q.pop_front();
          chk(bus_rx_data === e, "R5 rx order/contents", int'(bus_rx_data), int'(e));
        end
      end
      if (p_rxs) rx_q.push_back(eng_rx_data);
    end
  end

  initial begin
    #(20 * 50000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk1(tx_empty, 1'b1, "R1 tx_empty");
    chk1(tx_full, 1'b0, "R1 tx_full");
    chk1(rx_empty, 1'b1, "R1 rx_empty");
    chk1(rx_full, 1'b0, "R1 rx_full");
    chk1(tx_empty_next | tx_full_next | rx_empty_next | rx_full_next, 1'b0, "R1 next flags");
    chk1(tx_underrun_seen | rx_overflow_seen, 1'b0, "R1 sticky flags");
    chk1(bus_tx_ready, 1'b1, "R1 bus_tx_ready");
    chk1(eng_tx_valid, 1'b0, "R9 eng_tx_valid when empty");

    // Fill the transmit queue
    bus_tx_valid = 1;
    for (int i = 0; i < DEPTH - 1; i++) begin
      bus_tx_data = 8'(8'h10 + i);
      step();
    end
    chk1(tx_full_next, 1'b1, "R3 tx_full_next at DEPTH-1");
    chk1(tx_full, 1'b0, "R3 tx not yet full");
    bus_tx_data = 8'h3F;
    step();
    chk1(tx_full, 1'b1, "R2 tx full at DEPTH");
    chk1(bus_tx_ready, 1'b0, "R9 bus_tx_ready low when full");
    bus_tx_data = 8'hEE;
    step();
    chk1(tx_full, 1'b1, "R2 write to full refused");

    // Push and pop on a full queue: only the pop happens
    bus_tx_data = 8'h77;
    eng_tx_ready = 1; eng_active = 1;
    step();
    bus_tx_valid = 0;
    chk1(tx_full, 1'b0, "R8 full push+pop leaves DEPTH-1");
    chk1(tx_full_next, 1'b1, "R8 full push+pop full_next");
    for (int i = 0; i < DEPTH - 2; i++) step();
    chk1(tx_empty_next, 1'b1, "R3 tx_empty_next at one frame");
    step();
    eng_tx_ready = 0;
    chk1(tx_empty, 1'b1, "R2 tx drained");

    // Underrun only while active
    eng_active = 0; eng_tx_ready = 1;
    step(); step();
    chk1(tx_underrun, 1'b0, "R6 no underrun when idle");
    chk1(tx_underrun_seen, 1'b0, "R6 no sticky when idle");
    eng_active = 1;
    step();
    chk1(tx_underrun, 1'b1, "R6 underrun pulse");
    chk1(tx_underrun_seen, 1'b1, "R6 underrun sticky set");
    eng_tx_ready = 0;
    step();
    chk1(tx_underrun, 1'b0, "R6 underrun is one cycle");
    chk1(tx_underrun_seen, 1'b1, "R6 sticky holds");

    // Push and pop on an empty queue: only the push happens
    eng_active = 0;
    bus_tx_valid = 1; bus_tx_data = 8'h55; eng_tx_ready = 1;
    step();
    bus_tx_valid = 0; eng_tx_ready = 0;
    chk1(tx_empty, 1'b0, "R8 empty push+pop keeps the push");
    chk1(tx_empty_next, 1'b1, "R8 empty push+pop count one");

    // Fill the receive queue
    eng_rx_valid = 1;
    for (int i = 0; i < DEPTH; i++) begin
      eng_rx_data = 8'(8'hA0 + i);
      step();
      if (i == DEPTH - 2) chk1(rx_full_next, 1'b1, "R3 rx_full_next");
    end
    chk1(rx_full, 1'b1, "R2 rx full at DEPTH");
    eng_rx_data = 8'hFF;
    step();
    chk1(rx_overflow, 1'b1, "R5 overflow pulse");
    chk1(rx_overflow_seen, 1'b1, "R5 overflow sticky");
    chk1(rx_rcvd, 1'b0, "R7 no rcvd on drop");
    chk1(rx_full, 1'b1, "R5 still full after drop");
    // Push while full with a bus read: push dropped, read happens
    eng_rx_data = 8'hEE; bus_rx_ready = 1;
    step();
    eng_rx_valid = 0;
    chk1(rx_full, 1'b0, "R8 rx full push+pop only pops");
    chk1(rx_overflow, 1'b1, "R5 overflow with concurrent read");
    for (int i = 0; i < DEPTH - 1; i++) step();
    bus_rx_ready = 0;
    chk1(rx_empty, 1'b1, "R2 rx drained");
    chk1(bus_rx_valid, 1'b0, "R9 bus_rx_valid when empty");
    chk1(rx_overflow_seen, 1'b1, "R5 sticky holds until clear");

    // Both clears in one cycle, with a push ignored
    eng_rx_valid = 1;
    for (int i = 0; i < 3; i++) begin eng_rx_data = 8'(8'h30 + i); step(); end
    tx_flush = 1; rx_flush = 1; eng_rx_data = 8'h99;
    step();
    tx_flush = 0; rx_flush = 0; eng_rx_valid = 0;
    chk1(tx_empty, 1'b1, "R4 tx cleared");
    chk1(rx_empty, 1'b1, "R4 rx cleared, push ignored");
    chk1(tx_underrun_seen, 1'b0, "R4 tx clear drops sticky");
    chk1(rx_overflow_seen, 1'b0, "R4 rx clear drops sticky");

    // Independent clear
    bus_tx_valid = 1; eng_rx_valid = 1;
    bus_tx_data = 8'h61; eng_rx_data = 8'h71; step();
    bus_tx_data = 8'h62; eng_rx_data = 8'h72; step();
    bus_tx_valid = 0; eng_rx_valid = 0;
    rx_flush = 1; step(); rx_flush = 0;
    chk1(rx_empty, 1'b1, "R4 rx clear alone");
    chk1(tx_empty, 1'b0, "R4 tx untouched by rx clear");
    eng_rx_valid = 1; eng_rx_data = 8'h42; step(); eng_rx_valid = 0;
    chk1(rx_empty_next, 1'b1, "R3 rx_empty_next");
    bus_rx_ready = 1; step(); bus_rx_ready = 0;
    eng_tx_ready = 1; eng_active = 1; step(); step();
    eng_tx_ready = 0; eng_active = 0;
    chk1(tx_empty, 1'b1, "R2 tx drained after clear test");
    step(); step();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule